// File: doc/BRIEF.md
# Round-Trip Link Delay Meter

This block estimates the one-way propagation delay from a ring node to its neighbour. On a start request it sends a probe pulse towards the neighbour and counts clock ticks, each one 10 ns at 100 MHz, until the echoed message raises the receive-valid line. The probe may be repeated 1, 2, 4 or 8 times. Each repeat is launched only once receive-valid has dropped again. The round-trip counts are summed. The sum is then shifted right to give the mean one-way delay as an unsigned fixed-point number with 4 fraction bits (24.4 by default), where the integer part counts 10 ns units.

The block also keeps the delay it was handed from upstream, which is its own distance from the ring head. Once its own measurement and that upstream value are both present, it presents their saturated sum for forwarding to the next node. A node at the head of the ring ties the upstream input to zero. A programmable timeout ends a probe that never returns. In that case an error flag is raised and the stored result is left unchanged.

Top module: `link_delay_meter`

## Requirements
- R1: While reset is high, and on the first cycle after it, probe_req, done, err, fwd_vld, own_delay and fwd_delay are all zero.
- R2: probe_req is high for exactly one cycle per probe. It is raised only at a clock edge where rx_valid is sampled low. After a start, and after each non-final return, the block waits for rx_valid to be low before it probes.
- R3: The sample for one probe equals the number of rising clock edges from the edge that raised probe_req up to the first edge that samples rx_valid high. rep_log2 values 0, 1, 2 and 3 select 1, 2, 4 and 8 probes, whose samples are summed.
- R4: One edge after the final return, done is high for exactly one cycle. In that same cycle own_delay equals (sum × 16) >> (1 + rep_log2): bits [3:0] are the fraction and the upper bits are whole ticks. own_delay changes in no other cycle.
- R5: If rx_valid is not sampled high within timeout_lim edges after the probe edge, err goes high on the edge numbered timeout_lim. The run then ends with no done pulse and own_delay is left unchanged. err stays high until the next accepted start, and the edge that accepts that start clears it.
- R6: start is ignored while a measurement is running.
- R7: Once an own result and an upstream value are both held, fwd_vld pulses for one cycle on the next edge. At that point fwd_delay = upstream + own_delay, and both held flags are consumed.
- R8: If upstream + own_delay does not fit in 28 bits, fwd_delay saturates to all ones (0xFFFFFFF).
- R9: An edge that samples up_vld high stores up_delay as the upstream value. A later up_vld replaces the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock, one tick = 10 ns |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a measurement (sampled while idle) |
| rep_log2 | input | 2 | log2 of the number of probes |
| timeout_lim | input | TMO_W | maximum ticks to wait for a return |
| rx_valid | input | 1 | receive-valid of the echoed message |
| probe_req | output | 1 | one-cycle request to send the sync probe |
| up_delay | input | DLY_W | delay received from upstream |
| up_vld | input | 1 | strobe for up_delay |
| own_delay | output | DLY_W | measured one-way delay, fixed point |
| done | output | 1 | one-cycle pulse when own_delay is updated |
| err | output | 1 | sticky timeout flag |
| fwd_delay | output | DLY_W | saturated upstream + own delay |
| fwd_vld | output | 1 | one-cycle pulse qualifying fwd_delay |

## Verification
The bench builds the block with its default parameters: 24 whole bits, 4 fraction bits and a 16-bit timeout counter. Every repeat selection is exercised, including one-tick round trips and eight-probe sums. Because the timeout limit is a run-time input, a small limit of 5 can force the timeout path quickly. A large upstream value is used to drive the 28-bit forward sum into saturation. Start requests arriving mid-run, and rx_valid held high at start, are covered by the cycle-by-cycle reference model.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_PROBE = 2'd2,
    ST_FIN   = 2'd3
  } ldm_state_t;
endpackage

// File: rtl/ldm_seq.sv
module ldm_seq #(
  parameter int TMO_W = 16,
  parameter int SEL_W = 2,
  parameter int ACC_W = TMO_W + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] rep_log2,
  input  logic [TMO_W-1:0] timeout_lim,
  input  logic             rx_valid,
  output logic             probe_req,
  output logic             fin,
  output logic [ACC_W-1:0] acc,
  output logic [SEL_W-1:0] sel_q,
  output logic             err
);
  import ldm_pkg::*;

  localparam int REP_W = (1 << SEL_W);

  ldm_state_t       state;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] lim_q;
  logic [REP_W-1:0] rep;
  logic [TMO_W:0]   cnt_nx;
  logic [REP_W-1:0] rep_nx;
  logic [REP_W-1:0] rep_tot;

  always_comb begin
    cnt_nx  = (TMO_W+1)'(cnt) + (TMO_W+1)'(1);
    rep_nx  = rep + REP_W'(1);
    rep_tot = REP_W'(1) << sel_q;
  end

  assign fin = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      probe_req <= 1'b0;
      cnt       <= '0;
      lim_q     <= '0;
      rep       <= '0;
      acc       <= '0;
      sel_q     <= '0;
      err       <= 1'b0;
    end else begin
      probe_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ARM;
            err   <= 1'b0;
            acc   <= '0;
            rep   <= '0;
            sel_q <= rep_log2;
            lim_q <= timeout_lim;
          end
        end
        ST_ARM: begin
          if (!rx_valid) begin
            probe_req <= 1'b1;
            cnt       <= '0;
            state     <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (rx_valid) begin
            acc <= acc + ACC_W'(cnt_nx);
            rep <= rep_nx;
            state <= (rep_nx == rep_tot) ? ST_FIN : ST_ARM;
          end else if (cnt_nx >= (TMO_W+1)'(lim_q)) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt_nx[TMO_W-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldm_scale.sv
module ldm_scale #(
  parameter int ACC_W  = 19,
  parameter int SEL_W  = 2,
  parameter int FRAC_W = 4,
  parameter int DLY_W  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic [ACC_W-1:0] acc,
  input  logic [SEL_W-1:0] sel_q,
  output logic [DLY_W-1:0] own_delay,
  output logic             done
);
  localparam int EXT_W = ACC_W + FRAC_W;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [SEL_W:0]   sh_amt;
  logic [DLY_W-1:0] scaled;

  always_comb begin
    ext     = {acc, {FRAC_W{1'b0}}};
    sh_amt  = (SEL_W+1)'(sel_q) + (SEL_W+1)'(1);
    shifted = ext >> sh_amt;
  end

  generate
    if (EXT_W >= DLY_W) begin : g_trunc
      assign scaled = shifted[DLY_W-1:0];
    end else begin : g_ext
      assign scaled = {{(DLY_W-EXT_W){1'b0}}, shifted};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      own_delay <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      if (fin) own_delay <= scaled;
    end
  end
endmodule

// File: rtl/ldm_fwd.sv
module ldm_fwd #(
  parameter int DLY_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] up_delay,
  input  logic             up_vld,
  input  logic [DLY_W-1:0] own_delay,
  input  logic             own_new,
  output logic [DLY_W-1:0] fwd_delay,
  output logic             fwd_vld
);
  logic             has_up;
  logic             has_own;
  logic [DLY_W-1:0] up_q;
  logic             fire;
  logic [DLY_W:0]   sum;
  logic [DLY_W-1:0] sat;

  always_comb begin
    fire = has_up & has_own;
    sum  = {1'b0, up_q} + {1'b0, own_delay};
    sat  = sum[DLY_W] ? {DLY_W{1'b1}} : sum[DLY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      has_up    <= 1'b0;
      has_own   <= 1'b0;
      up_q      <= '0;
      fwd_delay <= '0;
      fwd_vld   <= 1'b0;
    end else begin
      fwd_vld <= fire;
      if (fire) fwd_delay <= sat;
      has_up  <= (has_up & ~fire) | up_vld;
      has_own <= (has_own & ~fire) | own_new;
      if (up_vld) up_q <= up_delay;
    end
  end
endmodule

// File: rtl/link_delay_meter.sv
module link_delay_meter #(
  parameter int WHOLE_W = 24,
  parameter int FRAC_W  = 4,
  parameter int TMO_W   = 16,
  parameter int SEL_W   = 2,
  localparam int DLY_W  = WHOLE_W + FRAC_W,
  localparam int ACC_W  = TMO_W + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] rep_log2,
  input  logic [TMO_W-1:0] timeout_lim,
  input  logic             rx_valid,
  output logic             probe_req,
  input  logic [DLY_W-1:0] up_delay,
  input  logic             up_vld,
  output logic [DLY_W-1:0] own_delay,
  output logic             done,
  output logic             err,
  output logic [DLY_W-1:0] fwd_delay,
  output logic             fwd_vld
);
  logic             fin;
  logic [ACC_W-1:0] acc;
  logic [SEL_W-1:0] sel_q;

  ldm_seq #(.TMO_W(TMO_W), .SEL_W(SEL_W), .ACC_W(ACC_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rep_log2(rep_log2),
    .timeout_lim(timeout_lim), .rx_valid(rx_valid), .probe_req(probe_req),
    .fin(fin), .acc(acc), .sel_q(sel_q), .err(err)
  );

  ldm_scale #(.ACC_W(ACC_W), .SEL_W(SEL_W), .FRAC_W(FRAC_W), .DLY_W(DLY_W)) u_scale (
    .clk(clk), .rst(rst), .fin(fin), .acc(acc), .sel_q(sel_q),
    .own_delay(own_delay), .done(done)
  );

  ldm_fwd #(.DLY_W(DLY_W)) u_fwd (
    .clk(clk), .rst(rst), .up_delay(up_delay), .up_vld(up_vld),
    .own_delay(own_delay), .own_new(fin),
    .fwd_delay(fwd_delay), .fwd_vld(fwd_vld)
  );
endmodule

// File: rtl/ldm_chk.sv
module ldm_chk #(
  parameter int DLY_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             probe_req,
  input logic [DLY_W-1:0] own_delay,
  input logic             done,
  input logic             err,
  input logic [DLY_W-1:0] fwd_delay,
  input logic             fwd_vld
);
  // R2
  probe_gated_chk: assert property (@(posedge clk) disable iff (rst)
    probe_req |-> !$past(rx_valid));
  // R2
  probe_single_chk: assert property (@(posedge clk) disable iff (rst)
    probe_req |=> !probe_req);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4
  own_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(own_delay));
  // R5
  err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !done);
  // R7
  fwd_single_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_vld |=> !fwd_vld);
  // R8
  fwd_floor_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> fwd_delay >= own_delay);
endmodule

bind link_delay_meter ldm_chk #(.DLY_W(DLY_W)) u_ldm_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .probe_req(probe_req),
  .own_delay(own_delay), .done(done), .err(err),
  .fwd_delay(fwd_delay), .fwd_vld(fwd_vld)
);

// File: tb/test_link_delay_meter.sv
`timescale 1ns/1ps
module test_link_delay_meter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  rep_log2 = 2'd0;
  logic [15:0] timeout_lim = 16'd100;
  logic        rx_valid = 1'b0;
  logic        probe_req;
  logic [27:0] up_delay = '0;
  logic        up_vld = 1'b0;
  logic [27:0] own_delay;
  logic        done;
  logic        err;
  logic [27:0] fwd_delay;
  logic        fwd_vld;

  link_delay_meter i_link_delay_meter (
    .clk(clk), .rst(rst), .start(start), .rep_log2(rep_log2),
    .timeout_lim(timeout_lim), .rx_valid(rx_valid), .probe_req(probe_req),
    .up_delay(up_delay), .up_vld(up_vld), .own_delay(own_delay),
    .done(done), .err(err), .fwd_delay(fwd_delay), .fwd_vld(fwd_vld)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;

  // reference model state
  logic        e_req = 0, e_done = 0, e_err = 0, e_fv = 0;
  logic [27:0] e_own = '0, e_fwd = '0;
  bit          m_up = 0, m_own = 0;
  logic [27:0] m_upv = '0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    check(probe_req == e_req, "R2 R3 R6 probe_req", 32'(probe_req), 32'(e_req));
    check(done == e_done, "R4 done", 32'(done), 32'(e_done));
    check(own_delay == e_own, "R3 R4 R5 own_delay", 32'(own_delay), 32'(e_own));
    check(err == e_err, "R5 err", 32'(err), 32'(e_err));
    check(fwd_vld == e_fv, "R7 fwd_vld", 32'(fwd_vld), 32'(e_fv));
    check(fwd_delay == e_fwd, "R7 R8 R9 fwd_delay", 32'(fwd_delay), 32'(e_fwd));
  end

  task automatic tick();
    bit fire;
    logic [28:0] s;
    bit upin;
    logic [27:0] upd;
    fire = m_up && m_own;
    s = {1'b0, m_upv} + {1'b0, e_own};
    upin = up_vld;
    upd = up_delay;
    @(posedge clk); #1;
    e_req = 0; e_done = 0; e_fv = 0;
    if (fire) begin
      e_fv = 1;
      e_fwd = s[28] ? 28'hFFFFFFF : s[27:0];
      m_up = 0; m_own = 0;
    end
    if (upin) begin m_up = 1; m_upv = upd; end
  endtask

  task automatic give_up(input logic [27:0] v);
    up_delay = v; up_vld = 1; tick(); up_vld = 0;
  endtask

  // delays: base + i*stp for probe i
  task automatic measure(input int sel, input int base, input int stp, input int hold, input bit poke);
    int n;
    int sum;
    n = 1 << sel;
    sum = 0;
    rep_log2 = 2'(sel);
    if (hold > 0) rx_valid = 1;
    start = 1; tick(); start = 0; e_err = 0;
    for (int k = 0; k < hold; k++) tick();
    rx_valid = 0; tick(); e_req = 1;
    for (int i = 0; i < n; i++) begin
      int d;
      d = base + i * stp;
      sum += d;
      for (int j = 1; j < d; j++) begin
        if (poke && i == 0 && j == 1) start = 1; // R6: start mid-run
        tick();
        start = 0;
      end
      rx_valid = 1; tick();
      if (i == n - 1) begin
        tick(); e_done = 1;
        e_own = 28'((longint'(sum) * 16) >> (1 + sel));
        m_own = 1;
        rx_valid = 0;
      end else begin
        tick(); rx_valid = 0; tick(); e_req = 1;
      end
    end
    repeat (3) tick();
  endtask

  task automatic timeout_run(input int lim);
    timeout_lim = 16'(lim);
    rx_valid = 0;
    start = 1; tick(); start = 0; e_err = 0;
    tick(); e_req = 1;
    for (int j = 1; j < lim; j++) tick();
    tick(); e_err = 1;
    repeat (3) tick();
    timeout_lim = 16'd100;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(probe_req == 0 && done == 0 && err == 0 && fwd_vld == 0, "R1 reset flags",
          {28'd0, probe_req, done, err, fwd_vld}, 32'd0);
    check(own_delay == 0 && fwd_delay == 0, "R1 reset values", 32'(own_delay | fwd_delay), 32'd0);
    rst = 0;
    tick();
    cmp_on = 1;
    tick();
    measure(0, 10, 0, 0, 0);     // R3 single probe, 10 ticks -> 0x50
    give_up(28'h10);             // R7 forward after late upstream
    repeat (3) tick();
    measure(1, 7, 1, 0, 0);      // two probes 7,8
    give_up(28'h123);            // R9 upstream first
    measure(2, 3, 1, 0, 1);      // four probes, start poked mid-run
    measure(3, 1, 1, 3, 0);      // eight probes from 1 tick, rx high at start
    give_up(28'hFFFFFF0);        // R8 saturation
    repeat (3) tick();
    timeout_run(5);              // R5
    measure(0, 20, 0, 0, 0);     // clears err
    give_up(28'h5);
    give_up(28'h7);              // R9 replacement
    repeat (4) tick();
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule